// File: doc/BRIEF.md
# Bank-Switched Dual-Port Synchronous Memory

This block is a two-port synchronous memory whose shared word array is cut into equal, independent banks. Each port has its own clock, registers every address, data and control input on that clock, and owns a loadable address counter. This lets a port stream through consecutive words without presenting a fresh address each cycle. The two ports may work at the same moment anywhere in the array, as long as they sit in different banks.

Ownership is settled per bank. The registered bank field of one port is compared with the other's, not word address against word address. When both ports land in the same bank in the same cycle, neither access counts. Any write is dropped, a read returns a fixed poison word, and both ports raise a collision flag alongside the data slot of that access. Reads are pipelined over two clock edges. An output enable gates each port's data bus with no clock involved. The bank count and bank depth are parameters. Widening the bank field by one bit gives the depth-expanded organisation, and the collision rule then uses the wider field.

Top module: `bsdp_mem`

## Requirements
- R1: A port takes part in a cycle only when its select-low input is 0 and its select-high input is 1. In any other cycle nothing it presents has an effect: no write lands, no read is issued and its counter keeps its value.
- R2: A read captured on clock edge k puts the stored word on that port's data output after edge k+2. The output holds its previous value after edge k+1, and between reads.
- R3: A write is split into two 9-bit lanes. Byte-enable bit 0 writes data bits 8:0 and byte-enable bit 1 writes bits 17:9. A lane whose enable is 0 keeps its stored bits, and a later read returns the merged word.
- R4: Both ports may read or write in the same cycle when their bank fields differ, each with correct results and no collision flag. The bank field is the top BANK_BITS bits of the address.
- R5: When both selected ports hold the same bank field in the same cycle, neither write is performed. A read in that cycle returns the POISON word (default 18'h2BEEF). The collision output of both ports is 1 after edge k+2 for exactly one cycle.
- R6: With the load input at 1, the access uses the address input, and the counter takes that address.
- R7: With load 0 and advance 1, the access uses counter+1 and the counter takes that value. The counter spans the whole address including the bank bits, so the top address is followed by address 0.
- R8: With load 0 and advance 0, the access reuses the counter address and the counter does not change.
- R9: When output enable is 0, the port's data output reads 0 at once, with no clock edge needed. Setting it back to 1 shows the held word again.
- R10: The collision compare uses every bank bit, including the top one. Two addresses that differ only in the most significant bank bit do not collide.
- R11: After reset, both data outputs and both collision flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Active-low asynchronous reset of both ports |
| a_csel_n | input | 1 | Port A select, active low |
| a_csel | input | 1 | Port A select, active high |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | 2 | Port A lane enables for writes |
| a_ld | input | 1 | Port A load address into counter |
| a_adv | input | 1 | Port A advance counter |
| a_addr | input | BANK_BITS+OFS_BITS | Port A address |
| a_din | input | 18 | Port A write data |
| a_drive_en | input | 1 | Port A output enable, asynchronous |
| a_dout | output | 18 | Port A read data |
| a_clash | output | 1 | Port A collision flag, aligned with read data |
| b_csel_n | input | 1 | Port B select, active low |
| b_csel | input | 1 | Port B select, active high |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | 2 | Port B lane enables for writes |
| b_ld | input | 1 | Port B load address into counter |
| b_adv | input | 1 | Port B advance counter |
| b_addr | input | BANK_BITS+OFS_BITS | Port B address |
| b_din | input | 18 | Port B write data |
| b_drive_en | input | 1 | Port B output enable, asynchronous |
| b_dout | output | 18 | Port B read data |
| b_clash | output | 1 | Port B collision flag, aligned with read data |

## Verification
The two functions that can fall in one cycle are a write on one port and a read on the other. The test provokes this twice in lockstep. Once the ports sit in different banks, including a pair that differs only in the top bank bit, and both results must be correct. Once they share a bank, and then the reading port must see poison, both flags must rise for a single cycle, and separate reads afterwards must show that neither stored word changed.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = 2 * LANE_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {AM_HOLD, AM_STEP, AM_LOAD} amode_e;

  // load wins over advance; neither keeps the counter address
  function automatic amode_e pick_mode(logic ld, logic adv);
    if (ld) return AM_LOAD;
    if (adv) return AM_STEP;
    return AM_HOLD;
  endfunction

  function automatic word_t merge_lanes(word_t old_w, word_t new_w, logic [1:0] be);
    word_t m;
    m = old_w;
    if (be[0]) m[LANE_W-1:0] = new_w[LANE_W-1:0];
    if (be[1]) m[WORD_W-1:LANE_W] = new_w[WORD_W-1:LANE_W];
    return m;
  endfunction
endpackage

// File: rtl/bsdp_store.sv
module bsdp_store
  import bsdp_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic          clk_a,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [1:0]    a_be,
  input  word_t         a_din,
  output word_t         a_rd,
  input  logic          clk_b,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [1:0]    b_be,
  input  word_t         b_din,
  output word_t         b_rd
);
  localparam int unsigned WORDS = 1 << AW;

  // each plane has one writer; the stored word is the XOR of both planes
  word_t plane_a [WORDS];
  word_t plane_b [WORDS];

  assign a_rd = plane_a[a_addr] ^ plane_b[a_addr];
  assign b_rd = plane_a[b_addr] ^ plane_b[b_addr];

  always_ff @(posedge clk_a) begin
    if (a_wr) plane_a[a_addr] <= merge_lanes(a_rd, a_din, a_be) ^ plane_b[a_addr];
  end

  always_ff @(posedge clk_b) begin
    if (b_wr) plane_b[b_addr] <= merge_lanes(b_rd, b_din, b_be) ^ plane_a[b_addr];
  end
endmodule

// File: rtl/bsdp_port.sv
module bsdp_port
  import bsdp_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter word_t POISON = 18'h2BEEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csel_n,
  input  logic          csel,
  input  logic          we,
  input  logic [1:0]    be,
  input  logic          ld,
  input  logic          adv,
  input  logic [AW-1:0] addr,
  input  word_t         din,
  input  logic          drive_en,
  input  logic          clash_now,
  input  word_t         arr_rd,
  output logic          go,
  output logic          live,
  output logic [AW-1:0] acc_addr,
  output logic          wr_fire,
  output logic [1:0]    wr_be,
  output word_t         wr_data,
  output logic [AW-1:0] ctr,
  output logic          s2_rd,
  output logic          s2_conf,
  output word_t         dout,
  output logic          clash
);
  logic [AW-1:0] eff;
  logic          s1_we;
  word_t         s2_data;
  word_t         q;

  assign go = ~csel_n & csel;

  always_comb begin
    unique case (pick_mode(ld, adv))
      AM_LOAD: eff = addr;
      AM_STEP: eff = ctr + 1'b1;
      default: eff = ctr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live     <= 1'b0;
      ctr      <= '0;
      acc_addr <= '0;
      s1_we    <= 1'b0;
      wr_be    <= '0;
      wr_data  <= '0;
      s2_rd    <= 1'b0;
      s2_conf  <= 1'b0;
      s2_data  <= '0;
      q        <= '0;
      clash    <= 1'b0;
    end else begin
      // capture stage
      live <= go;
      if (go) begin
        ctr      <= eff;
        acc_addr <= eff;
        s1_we    <= we;
        wr_be    <= be;
        wr_data  <= din;
      end
      // array stage
      s2_rd   <= live & ~s1_we;
      s2_conf <= live & clash_now;
      s2_data <= clash_now ? POISON : arr_rd;
      // output stage
      if (s2_rd) q <= s2_data;
      clash <= s2_conf;
    end
  end

  assign wr_fire = live & s1_we & ~clash_now;
  assign dout    = drive_en ? q : '0;
endmodule

// File: rtl/bsdp_mem.sv
module bsdp_mem
  import bsdp_pkg::*;
#(
  parameter int unsigned BANK_BITS = 3,
  parameter int unsigned OFS_BITS  = 3,
  parameter word_t       POISON    = 18'h2BEEF,
  localparam int unsigned AW       = BANK_BITS + OFS_BITS
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          a_csel_n,
  input  logic          a_csel,
  input  logic          a_we,
  input  logic [1:0]    a_be,
  input  logic          a_ld,
  input  logic          a_adv,
  input  logic [AW-1:0] a_addr,
  input  logic [17:0]   a_din,
  input  logic          a_drive_en,
  output logic [17:0]   a_dout,
  output logic          a_clash,
  input  logic          b_csel_n,
  input  logic          b_csel,
  input  logic          b_we,
  input  logic [1:0]    b_be,
  input  logic          b_ld,
  input  logic          b_adv,
  input  logic [AW-1:0] b_addr,
  input  logic [17:0]   b_din,
  input  logic          b_drive_en,
  output logic [17:0]   b_dout,
  output logic          b_clash
);
  function automatic logic [BANK_BITS-1:0] bank_of(logic [AW-1:0] ad);
    return BANK_BITS'(ad >> OFS_BITS);
  endfunction

  logic          a_go, a_live, a_wr_fire, a_s2_rd, a_s2_conf;
  logic          b_go, b_live, b_wr_fire, b_s2_rd, b_s2_conf;
  logic [AW-1:0] a_acc, a_ctr, b_acc, b_ctr;
  logic [1:0]    a_wr_be, b_wr_be;
  word_t         a_wr_data, b_wr_data, a_arr_rd, b_arr_rd;
  logic          clash_now;

  assign clash_now = a_live & b_live & (bank_of(a_acc) == bank_of(b_acc));

  bsdp_port #(.AW(AW), .POISON(POISON)) u_port_a (
    .clk(clk_a), .rst_n(rst_n), .csel_n(a_csel_n), .csel(a_csel), .we(a_we),
    .be(a_be), .ld(a_ld), .adv(a_adv), .addr(a_addr), .din(a_din),
    .drive_en(a_drive_en), .clash_now(clash_now), .arr_rd(a_arr_rd),
    .go(a_go), .live(a_live), .acc_addr(a_acc), .wr_fire(a_wr_fire),
    .wr_be(a_wr_be), .wr_data(a_wr_data), .ctr(a_ctr), .s2_rd(a_s2_rd),
    .s2_conf(a_s2_conf), .dout(a_dout), .clash(a_clash)
  );

  bsdp_port #(.AW(AW), .POISON(POISON)) u_port_b (
    .clk(clk_b), .rst_n(rst_n), .csel_n(b_csel_n), .csel(b_csel), .we(b_we),
    .be(b_be), .ld(b_ld), .adv(b_adv), .addr(b_addr), .din(b_din),
    .drive_en(b_drive_en), .clash_now(clash_now), .arr_rd(b_arr_rd),
    .go(b_go), .live(b_live), .acc_addr(b_acc), .wr_fire(b_wr_fire),
    .wr_be(b_wr_be), .wr_data(b_wr_data), .ctr(b_ctr), .s2_rd(b_s2_rd),
    .s2_conf(b_s2_conf), .dout(b_dout), .clash(b_clash)
  );

  bsdp_store #(.AW(AW)) u_store (
    .clk_a(clk_a), .a_wr(a_wr_fire), .a_addr(a_acc), .a_be(a_wr_be),
    .a_din(a_wr_data), .a_rd(a_arr_rd),
    .clk_b(clk_b), .b_wr(b_wr_fire), .b_addr(b_acc), .b_be(b_wr_be),
    .b_din(b_wr_data), .b_rd(b_arr_rd)
  );
endmodule

// File: rtl/bsdp_mem_chk.sv
module bsdp_mem_chk
  import bsdp_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter word_t POISON = 18'h2BEEF
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          a_csel_n,
  input logic          a_csel,
  input logic          a_ld,
  input logic          a_adv,
  input logic [AW-1:0] a_addr,
  input logic          b_csel_n,
  input logic          b_csel,
  input logic [17:0]   a_dout,
  input logic          a_clash,
  input logic          b_clash,
  input logic          a_go,
  input logic          a_live,
  input logic [AW-1:0] a_ctr,
  input logic          a_s2_rd,
  input logic          a_s2_conf,
  input logic          a_drive_en,
  input logic          b_live,
  input logic          clash_now
);
  p_deselect_idle_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(!a_csel_n && a_csel) |=> !a_live);

  p_deselect_idle_b_r1: assert property (@(posedge clk_b) disable iff (!rst_n)
    !(!b_csel_n && b_csel) |=> !b_live);

  p_load_ctr_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_go && a_ld) |=> a_ctr == $past(a_addr));

  p_step_ctr_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_go && !a_ld && a_adv) |=> a_ctr == AW'($past(a_ctr) + 1'b1));

  p_hold_ctr_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_go || (!a_ld && !a_adv)) |=> $stable(a_ctr));

  p_clash_flag_a_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_live && clash_now) |=> ##1 a_clash);

  p_clash_flag_b_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_live && clash_now) |=> ##1 b_clash);

  p_poison_out_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_s2_rd && a_s2_conf) |=> (a_dout == POISON || !a_drive_en));
endmodule

bind bsdp_mem bsdp_mem_chk #(.AW(AW), .POISON(POISON)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_csel_n(a_csel_n), .a_csel(a_csel), .a_ld(a_ld), .a_adv(a_adv),
  .a_addr(a_addr), .b_csel_n(b_csel_n), .b_csel(b_csel),
  .a_dout(a_dout), .a_clash(a_clash), .b_clash(b_clash),
  .a_go(a_go), .a_live(a_live), .a_ctr(a_ctr), .a_s2_rd(a_s2_rd),
  .a_s2_conf(a_s2_conf), .a_drive_en(a_drive_en), .b_live(b_live),
  .clash_now(clash_now)
);

// File: tb/sim_bsdp_mem.sv
`timescale 1ns/1ps
module sim_bsdp_mem;
  localparam int AW = 6;
  localparam logic [17:0] POISON = 18'h2BEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_csel_n = 1'b1, a_csel = 1'b0, a_we = 1'b0, a_ld = 1'b0, a_adv = 1'b0;
  logic b_csel_n = 1'b1, b_csel = 1'b0, b_we = 1'b0, b_ld = 1'b0, b_adv = 1'b0;
  logic [1:0] a_be = 2'b00, b_be = 2'b00;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [17:0] a_din = '0, b_din = '0;
  logic a_drive_en = 1'b1, b_drive_en = 1'b1;
  logic [17:0] a_dout, b_dout;
  logic a_clash, b_clash;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bsdp_mem u0 (
    .clk_a(clk), .clk_b(clk), .rst_n(rst_n),
    .a_csel_n(a_csel_n), .a_csel(a_csel), .a_we(a_we), .a_be(a_be),
    .a_ld(a_ld), .a_adv(a_adv), .a_addr(a_addr), .a_din(a_din),
    .a_drive_en(a_drive_en), .a_dout(a_dout), .a_clash(a_clash),
    .b_csel_n(b_csel_n), .b_csel(b_csel), .b_we(b_we), .b_be(b_be),
    .b_ld(b_ld), .b_adv(b_adv), .b_addr(b_addr), .b_din(b_din),
    .b_drive_en(b_drive_en), .b_dout(b_dout), .b_clash(b_clash)
  );

  task automatic chk(input string req, input logic [17:0] got, input logic [17:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input int p, input logic cs_n, input logic cs, input logic we,
                       input logic [1:0] be, input logic ld, input logic adv,
                       input logic [AW-1:0] ad, input logic [17:0] dt);
    if (p == 0) begin
      a_csel_n = cs_n; a_csel = cs; a_we = we; a_be = be;
      a_ld = ld; a_adv = adv; a_addr = ad; a_din = dt;
    end else begin
      b_csel_n = cs_n; b_csel = cs; b_we = we; b_be = be;
      b_ld = ld; b_adv = adv; b_addr = ad; b_din = dt;
    end
  endtask

  task automatic idle(input int p);
    drive(p, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic write1(input int p, input logic [AW-1:0] ad, input logic [17:0] dt,
                        input logic [1:0] be);
    @(negedge clk) drive(p, 1'b0, 1'b1, 1'b1, be, 1'b1, 1'b0, ad, dt);
    @(negedge clk) idle(p);
    @(negedge clk);
  endtask

  task automatic read1(input int p, input logic ld, input logic adv,
                       input logic [AW-1:0] ad, output logic [17:0] v);
    @(negedge clk) drive(p, 1'b0, 1'b1, 1'b0, 2'b00, ld, adv, ad, '0);
    @(negedge clk) idle(p);
    @(negedge clk);
    @(negedge clk);
    v = (p == 0) ? a_dout : b_dout;
  endtask

  task automatic t_reset();
    chk("R11 a_dout", a_dout, '0);
    chk("R11 b_dout", b_dout, '0);
    chk("R11 a_clash", {17'd0, a_clash}, '0);
    chk("R11 b_clash", {17'd0, b_clash}, '0);
  endtask

  task automatic t_shared();
    logic [17:0] v;
    write1(0, 6'h05, 18'h2A5A5, 2'b11);
    read1(0, 1'b1, 1'b0, 6'h05, v);
    chk("R2 R6 read own write", v, 18'h2A5A5);
    read1(1, 1'b1, 1'b0, 6'h05, v);
    chk("R4 other port sees write", v, 18'h2A5A5);
  endtask

  task automatic t_latency();
    write1(0, 6'h09, 18'h12345, 2'b11);
    @(negedge clk) drive(0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 6'h09, '0);
    @(negedge clk) idle(0);
    @(negedge clk);
    chk("R2 not yet after k+1", a_dout, 18'h2A5A5);
    @(negedge clk);
    chk("R2 valid after k+2", a_dout, 18'h12345);
  endtask

  task automatic t_lanes();
    logic [17:0] v;
    write1(0, 6'h11, 18'h3FFFF, 2'b11);
    write1(0, 6'h11, 18'h00000, 2'b01);
    read1(0, 1'b1, 1'b0, 6'h11, v);
    chk("R3 low lane only", v, 18'h3FE00);
    write1(1, 6'h11, 18'h15555, 2'b10);
    read1(1, 1'b1, 1'b0, 6'h11, v);
    chk("R3 high lane only", v, 18'h15400);
  endtask

  task automatic t_deselect();
    logic [17:0] v;
    write1(0, 6'h2D, 18'h12121, 2'b11);
    @(negedge clk) drive(0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h2D, '0);
    @(negedge clk) drive(0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 6'h2D, '0);
    @(negedge clk) idle(0);
    @(negedge clk);
    read1(0, 1'b1, 1'b0, 6'h2D, v);
    chk("R1 deselected writes ignored", v, 18'h12121);
  endtask

  task automatic t_parallel();
    logic [17:0] va, vb;
    @(negedge clk);
    drive(0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h0C, 18'h00C0C);
    drive(1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h14, 18'h01414);
    @(negedge clk) begin idle(0); idle(1); end
    @(negedge clk);
    drive(0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 6'h14, '0);
    drive(1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 6'h0C, '0);
    @(negedge clk) begin idle(0); idle(1); end
    @(negedge clk);
    @(negedge clk);
    va = a_dout; vb = b_dout;
    chk("R4 a reads b's bank", va, 18'h01414);
    chk("R4 b reads a's bank", vb, 18'h00C0C);
    chk("R4 no clash", {16'd0, a_clash, b_clash}, '0);
  endtask

  task automatic t_clash();
    logic [17:0] v;
    write1(0, 6'h19, 18'h0AAAA, 2'b11);
    write1(1, 6'h1A, 18'h15555, 2'b11);
    @(negedge clk);
    drive(0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h19, 18'h3FFFF);
    drive(1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 6'h1A, '0);
    @(negedge clk) begin idle(0); idle(1); end
    @(negedge clk);
    @(negedge clk);
    chk("R5 both flags up", {16'd0, a_clash, b_clash}, 18'd3);
    chk("R5 poison on read", b_dout, POISON);
    @(negedge clk);
    chk("R5 flags one cycle", {16'd0, a_clash, b_clash}, '0);
    read1(0, 1'b1, 1'b0, 6'h19, v);
    chk("R5 write suppressed", v, 18'h0AAAA);
    read1(1, 1'b1, 1'b0, 6'h1A, v);
    chk("R5 neighbour intact", v, 18'h15555);
  endtask

  task automatic t_topbit();
    logic [17:0] v;
    @(negedge clk);
    drive(0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h22, 18'h22222);
    drive(1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1, 1'b0, 6'h02, 18'h00202);
    @(negedge clk) begin idle(0); idle(1); end
    @(negedge clk);
    @(negedge clk);
    chk("R10 no clash on top bit", {16'd0, a_clash, b_clash}, '0);
    read1(1, 1'b1, 1'b0, 6'h22, v);
    chk("R10 high bank written", v, 18'h22222);
    read1(0, 1'b1, 1'b0, 6'h02, v);
    chk("R10 low bank written", v, 18'h00202);
  endtask

  task automatic t_counter();
    logic [17:0] v;
    write1(0, 6'h3F, 18'h3C3C3, 2'b11);
    write1(0, 6'h00, 18'h01001, 2'b11);
    write1(0, 6'h01, 18'h02002, 2'b11);
    read1(0, 1'b1, 1'b0, 6'h3F, v);
    chk("R6 load top address", v, 18'h3C3C3);
    read1(0, 1'b0, 1'b1, 6'h20, v);
    chk("R7 step wraps to 0", v, 18'h01001);
    read1(0, 1'b0, 1'b0, 6'h15, v);
    chk("R8 hold keeps 0", v, 18'h01001);
    read1(0, 1'b0, 1'b1, 6'h15, v);
    chk("R7 step to 1", v, 18'h02002);
  endtask

  task automatic t_oe();
    @(negedge clk) a_drive_en = 1'b0;
    #1 chk("R9 gated off", a_dout, '0);
    a_drive_en = 1'b1;
    #0.5 chk("R9 restored", a_dout, 18'h02002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shared();
    t_latency();
    t_lanes();
    t_deselect();
    t_parallel();
    t_clash();
    t_topbit();
    t_counter();
    t_oe();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule